// File: doc/BRIEF.md
# Triggerable Up-Counter Timer

This block is a 16-bit up-counting timer. The period value is programmable. The counter counts from zero up to the period value and returns to zero on the next advance. At every wrap the block emits a registered one-cycle overflow pulse. In repeat mode it keeps counting after a wrap. In one-shot mode it halts after the first wrap and lowers its running flag by itself.

Counting is started and stopped in two ways:
- Write-1 strobes from a register port. A halted counter keeps its value, and the next start resumes from that value.
- A hardware trigger picked from sixteen event inputs: eight external lines, one comparator output, six peer-timer triggers and one self trigger.

The trigger passes through a synchronizer and an edge detector. Its programmed action is one of start, stop, toggle or clear. Software clears the count by writing the counter register while the timer is halted.

Top module: `trig_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `count` = 0, `running` = 0 and `ovf` = 0.
- R2: A high `sw_start` at an edge sets `running` at that edge. The count does not change at that edge and rises by one at each later edge while running.
- R3: In repeat mode (`cfg_oneshot` = 0), the counter advances from `count` == `cfg_period` to 0 and keeps running. This covers `cfg_period` = 0, where the count stays 0 and wraps on every advance.
- R4: In one-shot mode (`cfg_oneshot` = 1), the edge that wraps the count to 0 also clears `running`. The counter then stays at 0.
- R5: A high `sw_stop` at an edge clears `running` and does not advance the count. The count holds while halted, and a later start resumes from the held value.
- R6: A high `cnt_wr` clears the count to 0 at that edge only while `running` is 0. While running, `cnt_wr` has no effect and the count still advances.
- R7: Triggers act only when `trig_en` = 1, and only `trig_in[trig_sel]` is used. Its input goes through a two-flop synchronizer. A rising edge sampled at clock edge k takes effect at edge k+2. A level held high yields one action.
- R8: The `trig_act` encoding is 0 = start, 1 = stop, 2 = toggle and 3 = clear. Toggle stops a running counter and starts a halted one. Clear zeroes the count whether running or not, and `running` is unchanged.
- R9: When a start request and a stop request fall in the same cycle, from any mix of strobe and trigger, the stop wins and `running` is 0 afterwards.
- R10: `ovf` is high for exactly the cycle after each wrap edge, in both modes. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | 16 | Terminal count value |
| cfg_oneshot | input | 1 | 1 = one-shot, 0 = repeat |
| sw_start | input | 1 | Write-1 start strobe |
| sw_stop | input | 1 | Write-1 stop strobe |
| cnt_wr | input | 1 | Counter write strobe (clears when halted) |
| trig_en | input | 1 | Enables trigger control |
| trig_sel | input | 4 | Index of the trigger input in use |
| trig_act | input | 2 | Trigger action: 0 start, 1 stop, 2 toggle, 3 clear |
| trig_in | input | 16 | Asynchronous trigger event inputs |
| running | output | 1 | Running-status flag |
| count | output | 16 | Current counter value |
| ovf | output | 1 | Registered one-cycle overflow pulse |

## Verification
The embedded assertions check, on every cycle:
- the plus-one step, the hold while halted and the clear result of the counter;
- the zero-and-pulse result of a wrap;
- the one-shot halt, and stop winning over start in the run flag.

Some behaviour only the bench scenarios can show:
- the three-edge latency of a trigger through the synchronizer;
- that a held trigger level acts once;
- that an unselected or disabled input is ignored;
- that a restart resumes from the held count.

The bench checks these at the ports.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  typedef enum logic [1:0] {
    ACT_START  = 2'd0,
    ACT_STOP   = 2'd1,
    ACT_TOGGLE = 2'd2,
    ACT_CLEAR  = 2'd3
  } trig_act_e;
endpackage

// File: rtl/trig_timer_sync.sv
module trig_timer_sync #(
  parameter int N_TRIG = 16,
  parameter int SEL_W  = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              en,
  output logic              hit
);
  logic [N_TRIG-1:0] meta_q, sync_q, last_q, rise;

  // One synchronizer plus edge detector per input line.
  for (genvar i = 0; i < N_TRIG; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        last_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= trig_in[i];
        sync_q[i] <= meta_q[i];
        last_q[i] <= sync_q[i];
      end
    end
    assign rise[i] = sync_q[i] & ~last_q[i];
  end

  assign hit = en & rise[sel];

  a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/trig_timer_ctrl.sv
module trig_timer_ctrl
  import trig_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_start,
  input  logic       sw_stop,
  input  logic       cnt_wr,
  input  logic       hit,
  input  logic [1:0] act,
  input  logic       oneshot,
  input  logic       wrap,
  output logic       running,
  output logic       adv,
  output logic       clr
);
  trig_act_e act_e;
  logic run_q, start_req, stop_req;

  assign act_e     = trig_act_e'(act);
  assign start_req = sw_start | (hit & (act_e == ACT_START))
                   | (hit & (act_e == ACT_TOGGLE) & ~run_q);
  assign stop_req  = sw_stop | (hit & (act_e == ACT_STOP))
                   | (hit & (act_e == ACT_TOGGLE) & run_q);
  assign adv = run_q & ~stop_req;
  assign clr = (hit & (act_e == ACT_CLEAR)) | (cnt_wr & ~run_q);

  always_ff @(posedge clk) begin
    if (rst)                  run_q <= 1'b0;
    else if (stop_req)        run_q <= 1'b0;
    else if (start_req)       run_q <= 1'b1;
    else if (wrap && oneshot) run_q <= 1'b0;
  end

  assign running = run_q;

  a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !running);
  a_r2_start_sets: assert property (@(posedge clk) disable iff (rst)
    (start_req && !stop_req) |=> running);
  a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
    (wrap && oneshot && !start_req) |=> !running);
endmodule

// File: rtl/trig_timer_core.sv
module trig_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  assign wrap = adv & ~clr & (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (clr)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (adv)  cnt_q <= cnt_q + ONE;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && cnt_q != period) |=> (cnt_q == $past(cnt_q) + ONE));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q));
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0 && ovf_q));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 16,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic              cfg_oneshot,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              cnt_wr,
  input  logic              trig_en,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [1:0]        trig_act,
  input  logic [N_TRIG-1:0] trig_in,
  output logic              running,
  output logic [CNT_W-1:0]  count,
  output logic              ovf
);
  logic hit, adv, clr, wrap;

  trig_timer_sync #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .sel(trig_sel),
    .en(trig_en), .hit(hit)
  );

  trig_timer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sw_start(sw_start), .sw_stop(sw_stop),
    .cnt_wr(cnt_wr), .hit(hit), .act(trig_act), .oneshot(cfg_oneshot),
    .wrap(wrap), .running(running), .adv(adv), .clr(clr)
  );

  trig_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .period(cfg_period), .adv(adv), .clr(clr),
    .count(count), .ovf(ovf), .wrap(wrap)
  );

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (count == '0 && !running && !ovf));
  a_r10_ovf_after_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (count == '0));
endmodule

// File: tb/trig_timer_bench.sv
module trig_timer_bench;
  localparam int W = 16;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  cfg_period;
  logic          cfg_oneshot, sw_start, sw_stop, cnt_wr, trig_en;
  logic [3:0]    trig_sel;
  logic [1:0]    trig_act;
  logic [N-1:0]  trig_in;
  logic          running, ovf;
  logic [W-1:0]  count;

  int n_tests = 0;
  int n_fail  = 0;
  int held;

  always #10 clk = ~clk;

  trig_timer u_trig_timer (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_oneshot(cfg_oneshot),
    .sw_start(sw_start), .sw_stop(sw_stop), .cnt_wr(cnt_wr),
    .trig_en(trig_en), .trig_sel(trig_sel), .trig_act(trig_act),
    .trig_in(trig_in), .running(running), .count(count), .ovf(ovf)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    sw_start = 1'b1; tick(1); sw_start = 1'b0;
  endtask

  task automatic pulse_stop();
    sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
  endtask

  task automatic pulse_wr();
    cnt_wr = 1'b1; tick(1); cnt_wr = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; cfg_period = 16'd5; cfg_oneshot = 1'b0;
    sw_start = 1'b0; sw_stop = 1'b0; cnt_wr = 1'b0; trig_en = 1'b0;
    trig_sel = 4'd3; trig_act = 2'd0; trig_in = '0;
    tick(3);
    rst = 1'b0;
    chk("R1 count", int'(count), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 ovf", int'(ovf), 0);

    // Repeat mode, period 5
    pulse_start();
    for (int j = 0; j <= 20; j++) begin
      chk("R2/R3 count", int'(count), j % 6);
      chk("R10 ovf", int'(ovf), (j > 0 && j % 6 == 0) ? 1 : 0);
      chk("R3 running", int'(running), 1);
      tick(1);
    end
    // now at j=21: count 3
    pulse_stop();
    chk("R5 stop running", int'(running), 0);
    chk("R5 stop holds", int'(count), 3);
    tick(4);
    chk("R5 held", int'(count), 3);
    pulse_start();
    chk("R5 resume value", int'(count), 3);
    tick(1);
    chk("R5 resume step", int'(count), 4);
    pulse_wr();
    chk("R6 write ignored while running", int'(count), 5);
    pulse_stop();
    chk("R5 halted", int'(count), 5);
    pulse_wr();
    chk("R6 write clears", int'(count), 0);
    chk("R6 still halted", int'(running), 0);

    // One-shot
    cfg_oneshot = 1'b1;
    pulse_start();
    for (int j = 0; j <= 7; j++) begin
      chk("R4 count", int'(count), (j <= 5) ? j : 0);
      chk("R4 running", int'(running), (j <= 5) ? 1 : 0);
      chk("R10 ovf oneshot", int'(ovf), (j == 6) ? 1 : 0);
      tick(1);
    end
    tick(3);
    chk("R4 stays zero", int'(count), 0);
    chk("R10 no ovf", int'(ovf), 0);
    cfg_oneshot = 1'b0;

    // Period sweep in repeat mode
    for (int p = 0; p <= 4; p++) begin
      cfg_period = W'(p);
      pulse_start();
      for (int j = 0; j <= 12; j++) begin
        chk("R3 sweep count", int'(count), j % (p + 1));
        chk("R10 sweep ovf", int'(ovf), (j > 0 && j % (p + 1) == 0) ? 1 : 0);
        tick(1);
      end
      pulse_stop();
      pulse_wr();
      chk("R6 sweep clear", int'(count), 0);
    end

    // Triggers
    cfg_period = 16'd200;
    trig_act = 2'd0;
    trig_in[3] = 1'b1; tick(4);
    chk("R7 disabled", int'(running), 0);
    trig_in[3] = 1'b0; tick(3);
    trig_en = 1'b1;
    trig_in[5] = 1'b1; tick(4);
    chk("R7 unselected", int'(running), 0);
    trig_in[5] = 1'b0; tick(3);
    trig_in[3] = 1'b1; tick(2);
    chk("R7 latency not yet", int'(running), 0);
    tick(1);
    chk("R7 latency start", int'(running), 1);
    chk("R7 count at start", int'(count), 0);
    tick(5);
    chk("R2 trig counting", int'(count), 5);
    trig_act = 2'd2; tick(5);
    chk("R7 level acts once", int'(running), 1);
    trig_in[3] = 1'b0; tick(3);
    trig_act = 2'd1;
    trig_in[3] = 1'b1; tick(3);
    chk("R8 stop action", int'(running), 0);
    held = int'(count);
    trig_in[3] = 1'b0; tick(3);
    chk("R8 stop holds", int'(count), held);
    trig_act = 2'd2;
    trig_in[3] = 1'b1; tick(3);
    chk("R8 toggle on", int'(running), 1);
    trig_in[3] = 1'b0; tick(3);
    trig_in[3] = 1'b1; tick(3);
    chk("R8 toggle off", int'(running), 0);
    trig_in[3] = 1'b0; tick(3);
    trig_act = 2'd3;
    trig_in[3] = 1'b1; tick(3);
    chk("R8 clear halted", int'(count), 0);
    chk("R8 clear keeps halted", int'(running), 0);
    trig_in[3] = 1'b0; tick(3);
    pulse_start(); tick(4);
    trig_in[3] = 1'b1; tick(3);
    chk("R8 clear running", int'(count), 0);
    chk("R8 clear still running", int'(running), 1);
    tick(2);
    chk("R8 counts after clear", int'(count), 2);
    trig_in[3] = 1'b0; tick(3);

    // Priority
    pulse_stop();
    sw_start = 1'b1; sw_stop = 1'b1; tick(1);
    sw_start = 1'b0; sw_stop = 1'b0;
    chk("R9 strobes both", int'(running), 0);
    trig_act = 2'd0;
    trig_in[3] = 1'b1; tick(2);
    sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
    chk("R9 trig start vs stop", int'(running), 0);
    trig_in[3] = 1'b0; tick(3);
    pulse_start();
    trig_act = 2'd1;
    trig_in[3] = 1'b1; tick(2);
    sw_start = 1'b1; tick(1); sw_start = 1'b0;
    chk("R9 trig stop vs start", int'(running), 0);
    trig_in[3] = 1'b0; tick(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule